// File: doc/BRIEF.md
# Serial Flash Status Protection Unit

This block is the status-register front end of a serial NOR flash slave that talks single-bit SPI in mode 0. It watches the chip-select, clock and data-in pins with the system clock, assembles command bytes and acts on four opcodes: set the write-enable latch, clear it, read the status byte, and write the status byte. It keeps two state bits: the write-enable latch and a status lock bit. It also tracks the level of an active-low write-protect pin.

Writes to the status byte are guarded in two ways. The write-enable latch must be set when the write opcode is decoded. The device must also not be in its locked state, which exists only while the protect pin is low and the lock bit is 1. When the pin is high, or the lock bit is 0, the device is in its unlocked state and status writes go through. An accepted write takes effect when chip select rises, and only if at least one full data byte was shifted in.

Memory array commands, multi-bit modes and the reset command pair are not handled here. The latch values are brought out as plain level outputs for the array logic to use.

Top module: `spi_status_guard`

## Requirements
- R1: After reset, `wel_o`, `srwd_o` and `spi_miso` are 0, and the protect level is taken as high.
- R2: Opcode 0x06 sets `wel_o` and opcode 0x04 clears it, each once the eighth opcode bit has been clocked in.
- R3: After opcode 0x05, `spi_miso` sends the status byte MSB first, and repeats it while chip select stays low. Bit 7 is the lock bit, bit 1 is the write-enable latch, and bits 0 and 2 to 6 read 0.
- R4: An accepted write (opcode 0x01) loads the lock bit from bit 7 of the first data byte when chip select rises, and clears `wel_o` at the same time.
- R5: If `wp_n` is low and the lock bit is 1 when opcode 0x01 is decoded, the write is rejected. Both `srwd_o` and `wel_o` keep their values.
- R6: If `wel_o` is 0 when opcode 0x01 is decoded, the command has no effect, whatever data follows.
- R7: If chip select rises before eight data bits have followed opcode 0x01, nothing changes, and `wel_o` stays set.
- R8: Data bytes after the first one in a write are ignored.
- R9: A write is accepted with `wp_n` low and the lock bit at 0, and also with `wp_n` high and the lock bit at 1.
- R10: Unknown opcodes change no state, and `spi_miso` stays 0 for every command except the status read.
- R11: The protection mode is judged once, when the opcode is decoded. A change of `wp_n` during the data byte of an accepted write does not cancel that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI pins are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| wp_n | input | 1 | Active-low write-protect level |
| wel_o | output | 1 | Write-enable latch |
| srwd_o | output | 1 | Status lock bit |

## Verification
Two events can meet in the same transaction: the check that decides whether a write is allowed, and a change in the level of the protect pin. The bench raises `wp_n` and issues an accepted write opcode. It then drives `wp_n` low between the opcode and the data byte, and expects the lock bit to take the new value anyway. A second meeting point is the chip-select rise, where the lock bit is loaded and the write-enable latch is cleared in one cycle. Both outputs are checked right after that rise, and a status read confirms the result.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam int SR_W = 8;

  localparam logic [SR_W-1:0] OP_WRSR = 8'h01;
  localparam logic [SR_W-1:0] OP_WRDI = 8'h04;
  localparam logic [SR_W-1:0] OP_RDSR = 8'h05;
  localparam logic [SR_W-1:0] OP_WREN = 8'h06;

  localparam int SR_WEL_BIT  = 1;
  localparam int SR_LOCK_BIT = 7;

  typedef enum logic [1:0] {
    PH_OPCODE,
    PH_READ,
    PH_WRITE,
    PH_DROP
  } phase_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_pin_front.sv
module spi_pin_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_raw,
  input  logic cs_n_raw,
  input  logic mosi_raw,
  input  logic wp_n_raw,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_active,
  output logic cs_rise,
  output logic mosi_s,
  output logic wp_lvl
);
  localparam int NPINS = 4;
  // bit order: sclk, cs_n, mosi, wp_n ; cs_n and wp_n idle high
  localparam logic [NPINS-1:0] RST_VALS = 4'b1010;

  logic [NPINS-1:0] raw;
  logic [NPINS-1:0] synced;
  logic             sclk_q;
  logic             cs_q;

  assign raw = {wp_n_raw, mosi_raw, cs_n_raw, sclk_raw};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    bit_sync #(.STAGES(STAGES), .RST_VAL(RST_VALS[g])) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw[g]),
      .q    (synced[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= synced[0];
      cs_q   <= synced[1];
    end
  end

  assign sclk_rise = synced[0] & ~sclk_q;
  assign sclk_fall = ~synced[0] & sclk_q;
  assign cs_active = ~synced[1];
  assign cs_rise   = synced[1] & ~cs_q;
  assign mosi_s    = synced[2];
  assign wp_lvl    = synced[3];
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx #(
  parameter int W = 8,
  localparam int CNT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_active,
  input  logic             sclk_rise,
  input  logic             mosi_s,
  output logic             byte_valid,
  output logic [W-1:0]     byte_data,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-2:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!cs_active) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      shreg   <= {shreg[W-3:0], mosi_s};
      bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
    end
  end

  assign byte_valid = cs_active & sclk_rise & (bit_cnt == LAST);
  assign byte_data  = {shreg, mosi_s};
endmodule

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import spi_sr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_active,
  input  logic            cs_rise,
  input  logic            byte_valid,
  input  logic [SR_W-1:0] byte_data,
  input  logic            wp_lvl,
  output logic            wel,
  output logic            srwd,
  output phase_e          phase,
  output logic            wr_armed
);
  logic got_byte;
  logic cap_lock;
  logic locked;

  assign locked   = ~wp_lvl & srwd;
  assign wr_armed = (phase == PH_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel      <= 1'b0;
      srwd     <= 1'b0;
      phase    <= PH_OPCODE;
      got_byte <= 1'b0;
      cap_lock <= 1'b0;
    end else if (cs_rise) begin
      if (phase == PH_WRITE && got_byte) begin
        srwd <= cap_lock;
        wel  <= 1'b0;
      end
      phase    <= PH_OPCODE;
      got_byte <= 1'b0;
    end else if (!cs_active) begin
      phase    <= PH_OPCODE;
      got_byte <= 1'b0;
    end else if (byte_valid) begin
      unique case (phase)
        PH_OPCODE: begin
          unique case (byte_data)
            OP_WREN: begin wel <= 1'b1; phase <= PH_DROP; end
            OP_WRDI: begin wel <= 1'b0; phase <= PH_DROP; end
            OP_RDSR: phase <= PH_READ;
            OP_WRSR: phase <= (wel && !locked) ? PH_WRITE : PH_DROP;
            default: phase <= PH_DROP;
          endcase
        end
        PH_WRITE: begin
          if (!got_byte) begin
            got_byte <= 1'b1;
            cap_lock <= byte_data[SR_LOCK_BIT];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
  import spi_sr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic wp_n,
  output logic wel_o,
  output logic srwd_o
);
  localparam int CNT_W = $clog2(SR_W);
  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(SR_W - 1);

  logic            sclk_rise, sclk_fall, cs_active, cs_rise, mosi_s, wp_lvl;
  logic            byte_valid;
  logic [SR_W-1:0] byte_data;
  logic [CNT_W-1:0] bit_cnt;
  phase_e          phase;
  logic            wr_armed;
  logic [SR_W-1:0] status_byte;
  logic            miso_q;

  spi_pin_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_raw (spi_sclk),
    .cs_n_raw (spi_cs_n),
    .mosi_raw (spi_mosi),
    .wp_n_raw (wp_n),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .cs_active(cs_active),
    .cs_rise  (cs_rise),
    .mosi_s   (mosi_s),
    .wp_lvl   (wp_lvl)
  );

  spi_byte_rx #(.W(SR_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_active (cs_active),
    .sclk_rise (sclk_rise),
    .mosi_s    (mosi_s),
    .byte_valid(byte_valid),
    .byte_data (byte_data),
    .bit_cnt   (bit_cnt)
  );

  sr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_active (cs_active),
    .cs_rise   (cs_rise),
    .byte_valid(byte_valid),
    .byte_data (byte_data),
    .wp_lvl    (wp_lvl),
    .wel       (wel_o),
    .srwd      (srwd_o),
    .phase     (phase),
    .wr_armed  (wr_armed)
  );

  always_comb begin
    status_byte              = '0;
    status_byte[SR_LOCK_BIT] = srwd_o;
    status_byte[SR_WEL_BIT]  = wel_o;
  end

  // mode 0: next bit goes out on the falling edge, picked by the bit counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            miso_q <= 1'b0;
    else if (!cs_active)                   miso_q <= 1'b0;
    else if (sclk_fall && phase == PH_READ) miso_q <= status_byte[TOP_IDX - bit_cnt];
  end

  assign spi_miso = miso_q;
endmodule

// File: rtl/spi_status_guard_chk.sv
module spi_status_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_active,
  input logic cs_rise,
  input logic byte_valid,
  input logic wp_lvl,
  input logic wr_armed,
  input logic wel_o,
  input logic srwd_o,
  input logic spi_miso
);
  // R2
  wel_set_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_o) |-> $past(byte_valid));

  // R4
  lock_moves_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(srwd_o) |-> $past(cs_rise));

  // R5
  hpm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_lvl && srwd_o && !wr_armed) |=> (srwd_o && !wr_armed));

  // R6
  arm_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_armed) |-> $past(wel_o));

  // R10
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> !spi_miso);
endmodule

bind spi_status_guard spi_status_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_active (cs_active),
  .cs_rise   (cs_rise),
  .byte_valid(byte_valid),
  .wp_lvl    (wp_lvl),
  .wr_armed  (wr_armed),
  .wel_o     (wel_o),
  .srwd_o    (srwd_o),
  .spi_miso  (spi_miso)
);

// File: tb/tb_spi_status_guard.sv
module tb_spi_status_guard;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso, wel, srwd;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  spi_status_guard dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .wp_n(wp_n), .wel_o(wel), .srwd_o(srwd)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[7-i];
      wait_clk(HALF);
      rx = {rx[6:0], miso};
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_open();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_close();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_open();
    spi_bits(op, 8, r);
    cs_close();
  endtask

  task automatic wrsr(input logic [7:0] d0);
    logic [7:0] r;
    cs_open();
    spi_bits(8'h01, 8, r);
    spi_bits(d0, 8, r);
    cs_close();
  endtask

  task automatic rdsr_check(input string req, input logic [7:0] exp);
    logic [7:0] r;
    cs_open();
    spi_bits(8'h05, 8, r);
    spi_bits(8'h00, 8, r);
    chk(req, r, exp);
    spi_bits(8'h00, 8, r);
    chk(req, r, exp);
    cs_close();
  endtask

  task automatic t_reset();
    chk("R1 wel", {7'd0, wel}, 8'h00);
    chk("R1 srwd", {7'd0, srwd}, 8'h00);
    chk("R1 miso", {7'd0, miso}, 8'h00);
    rdsr_check("R1 R3 status after reset", 8'h00);
  endtask

  task automatic t_wren_wrdi();
    cmd1(8'h06);
    chk("R2 wren", {7'd0, wel}, 8'h01);
    rdsr_check("R3 status with wel", 8'h02);
    cmd1(8'h04);
    chk("R2 wrdi", {7'd0, wel}, 8'h00);
  endtask

  task automatic t_no_wel();
    wrsr(8'h80);
    chk("R6 srwd unchanged", {7'd0, srwd}, 8'h00);
  endtask

  task automatic t_partial();
    logic [7:0] r;
    cmd1(8'h06);
    cs_open();
    spi_bits(8'h01, 8, r);
    spi_bits(8'hFF, 4, r);
    cs_close();
    chk("R7 srwd", {7'd0, srwd}, 8'h00);
    chk("R7 wel kept", {7'd0, wel}, 8'h01);
  endtask

  task automatic t_accept();
    logic [7:0] r;
    cs_open();
    spi_bits(8'h01, 8, r);
    spi_bits(8'h80, 8, r);
    spi_bits(8'h00, 8, r);
    cs_close();
    chk("R4 R8 srwd set", {7'd0, srwd}, 8'h01);
    chk("R4 wel cleared", {7'd0, wel}, 8'h00);
    rdsr_check("R3 status lock", 8'h80);
  endtask

  task automatic t_hpm();
    wp_n = 1'b0;
    wait_clk(4);
    cmd1(8'h06);
    wrsr(8'h00);
    chk("R5 srwd kept", {7'd0, srwd}, 8'h01);
    chk("R5 wel kept", {7'd0, wel}, 8'h01);
    rdsr_check("R5 status", 8'h82);
  endtask

  task automatic t_soft_modes();
    logic [7:0] r;
    wp_n = 1'b1;
    wait_clk(4);
    cs_open();
    spi_bits(8'h01, 8, r);
    spi_bits(8'h7F, 8, r);
    spi_bits(8'hFF, 8, r);
    cs_close();
    chk("R9 R8 clear with wp high", {7'd0, srwd}, 8'h00);
    chk("R4 wel cleared", {7'd0, wel}, 8'h00);
    wp_n = 1'b0;
    wait_clk(4);
    cmd1(8'h06);
    wrsr(8'h80);
    chk("R9 set with wp low", {7'd0, srwd}, 8'h01);
  endtask

  task automatic t_unknown();
    logic [7:0] r0, r1;
    cs_open();
    spi_bits(8'h9F, 8, r0);
    spi_bits(8'h00, 8, r1);
    cs_close();
    chk("R10 no miso data", r1, 8'h00);
    chk("R10 state", {6'd0, srwd, wel}, 8'h02);
  endtask

  task automatic t_wp_mid();
    logic [7:0] r;
    wp_n = 1'b1;
    wait_clk(4);
    cmd1(8'h06);
    cs_open();
    spi_bits(8'h01, 8, r);
    wp_n = 1'b0;
    spi_bits(8'h00, 8, r);
    cs_close();
    chk("R11 write kept", {7'd0, srwd}, 8'h00);
    chk("R11 wel cleared", {7'd0, wel}, 8'h00);
    rdsr_check("R11 status", 8'h00);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_wren_wrdi();
    t_no_wel();
    t_partial();
    t_accept();
    t_hpm();
    t_soft_modes();
    t_unknown();
    t_wp_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule